// File: doc/BRIEF.md
# Aligned Power-of-Two Range Splitter

This engine takes one address range, given as a start address and a byte length that are both multiples of a 4 KiB granule. It breaks the range into a sequence of chunks. Each chunk has a power-of-two size and starts on a multiple of that size, so a single base/mask pair describes it. The chunks lie in ascending address order and together cover the range exactly, with no gaps and no overlap. They come out one at a time on a valid/ready stream. Each chunk carries its base, its size and its match mask. A last flag marks the final chunk.

Each chunk is the largest power of two that meets two limits: the alignment of the current address and the length still remaining. As a result, chunk sizes first grow while the address gains alignment, and then shrink as the remainder runs out.

Some requests are refused. These are a misaligned start address, a misaligned length, and a range that would pass the top of the address space. A zero length produces no chunks. In every case the engine ends the request with a one-cycle done pulse. For a refusal or a zero length, that pulse carries an error flag or an empty flag.

Top module: `aligned_pow2_splitter`

## Requirements
- R1: Every chunk size is a power of two, and every chunk base is a multiple of its size.
- R2: Each chunk size is the largest power of two that satisfies two limits. It divides the current address, where address zero imposes no limit. It also does not exceed the remaining length. For example, 56 KiB at 0xA8642000 yields 8 KiB, 16 KiB and 32 KiB in that order. The same length at 0xE0000000 yields 32 KiB, 16 KiB and 8 KiB.
- R3: The mask output equals the bitwise inverse of (size − 1), taken over the 32-bit address width.
- R4: Chunks start at the request address and follow each other contiguously until the range ends. The last flag is high only on the final chunk. The stream goes idle after the handshake on that chunk.
- R5: While a chunk is offered and not accepted, its base, mask, size and last flag stay unchanged.
- R6: A range that is already a power of two in size and aligned to that size produces exactly one chunk.
- R7: A zero length produces no chunks. Done and empty are both high in the cycle after the request is accepted.
- R8: A start address or length with any of its low 12 bits set is rejected: no chunks, and done and error are high in the cycle after acceptance. This check takes precedence over the zero-length case, so empty stays low.
- R9: A range whose end exceeds 2^32 is rejected in the same way as in R8. A range ending exactly at 2^32 is accepted.
- R10: The request port is ready only while no range is in progress. After the final chunk's handshake, done is high for exactly one cycle, with error and empty low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Engine is idle and accepts a request |
| req_addr | input | 32 | Start address of the range |
| req_len | input | 32 | Length of the range in bytes |
| chk_valid | output | 1 | A chunk is offered |
| chk_ready | input | 1 | Consumer accepts the chunk |
| chk_base | output | 32 | Chunk base address |
| chk_mask | output | 32 | Chunk match mask |
| chk_size | output | 32 | Chunk size in bytes |
| chk_last | output | 1 | Final chunk of the range |
| done | output | 1 | One-cycle end-of-request pulse |
| empty | output | 1 | With done: the request had zero length |
| err | output | 1 | With done: the request was rejected |

## Verification
Two verdicts can apply to one request in the same cycle: misalignment and zero length. This happens when the length is zero and the address has low bits set. The bench issues exactly that request and checks that error alone accompanies done, with empty low. A second overlap is the acceptance test and the wrap test at the very top of the address space. Here the bench issues one range that ends exactly at 2^32 and one that exceeds it by a single granule. It expects a normal chunk stream for the first and a refusal for the second.

// File: rtl/aligned_pow2_splitter.sv
module aligned_pow2_splitter #(
  parameter int AW   = 32,
  parameter int GRAN = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_len,
  output logic          chk_valid,
  input  logic          chk_ready,
  output logic [AW-1:0] chk_base,
  output logic [AW-1:0] chk_mask,
  output logic [AW-1:0] chk_size,
  output logic          chk_last,
  output logic          done,
  output logic          empty,
  output logic          err
);

  logic          busy;
  logic [AW-1:0] cur, rem;
  logic [AW-1:0] len_lim, aln_lim;
  logic [AW:0]   end_sum;
  logic          misaligned, wraps;

  assign end_sum    = {1'b0, req_addr} + {1'b0, req_len};
  assign wraps      = end_sum[AW] && (end_sum[AW-1:0] != '0);
  assign misaligned = (req_addr[GRAN-1:0] != '0) || (req_len[GRAN-1:0] != '0);

  always_comb begin
    len_lim = '0;
    for (int i = 0; i < AW; i++) begin
      if (rem[i]) begin
        len_lim    = '0;
        len_lim[i] = 1'b1;
      end
    end
  end

  assign aln_lim = cur & (~cur + 1'b1);

  assign chk_size  = (cur == '0 || len_lim < aln_lim) ? len_lim : aln_lim;
  assign chk_mask  = ~(chk_size - 1'b1);
  assign chk_base  = cur;
  assign chk_last  = (chk_size == rem);
  assign chk_valid = busy;
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cur   <= '0;
      rem   <= '0;
      done  <= 1'b0;
      empty <= 1'b0;
      err   <= 1'b0;
    end else begin
      done  <= 1'b0;
      empty <= 1'b0;
      err   <= 1'b0;
      if (!busy && req_valid) begin
        if (misaligned || wraps) begin
          err  <= 1'b1;
          done <= 1'b1;
        end else if (req_len == '0) begin
          empty <= 1'b1;
          done  <= 1'b1;
        end else begin
          busy <= 1'b1;
          cur  <= req_addr;
          rem  <= req_len;
        end
      end else if (busy && chk_ready) begin
        cur <= cur + chk_size;
        rem <= rem - chk_size;
        if (chk_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aligned_pow2_splitter_chk.sv
module aligned_pow2_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          chk_valid,
  input logic          chk_ready,
  input logic [AW-1:0] chk_base,
  input logic [AW-1:0] chk_mask,
  input logic [AW-1:0] chk_size,
  input logic          chk_last,
  input logic          done,
  input logic          empty,
  input logic          err
);

  p_pow2_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $countones(chk_size) == 1);

  p_base_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_base & (chk_size - 1'b1)) == '0);

  p_mask_keeps_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> ((chk_base & chk_mask) == chk_base) && ((chk_mask & chk_size) == chk_size));

  p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_ready |=> chk_valid && $stable(chk_base) && $stable(chk_size)
                               && $stable(chk_mask) && $stable(chk_last));

  p_busy_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !req_ready);

  p_last_then_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ready && chk_last |=> done && !err && !empty && !chk_valid);

  p_flag_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err || empty) |-> done && !(err && empty));

endmodule

bind aligned_pow2_splitter aligned_pow2_splitter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .chk_valid(chk_valid),
  .chk_ready(chk_ready), .chk_base(chk_base), .chk_mask(chk_mask),
  .chk_size(chk_size), .chk_last(chk_last), .done(done), .empty(empty), .err(err)
);

// File: tb/aligned_pow2_splitter_tb.sv
module aligned_pow2_splitter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_len = '0;
  logic        chk_valid;
  logic        chk_ready = 1'b0;
  logic [31:0] chk_base, chk_mask, chk_size;
  logic        chk_last, done, empty, err;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aligned_pow2_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .chk_valid(chk_valid),
    .chk_ready(chk_ready), .chk_base(chk_base), .chk_mask(chk_mask),
    .chk_size(chk_size), .chk_last(chk_last), .done(done), .empty(empty), .err(err)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pick(input logic [63:0] c, input logic [63:0] r);
    for (int k = 31; k >= 12; k--) begin
      logic [63:0] s;
      s = 64'd1 << k;
      if ((c % s) == 0 && s <= r) return s;
    end
    return 64'd0;
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] l,
                     input bit rnd_ready, output int nchunks);
    logic [63:0] cur, rem, sz;
    bit rej, emp, stalled;
    cur = {32'd0, a};
    rem = {32'd0, l};
    rej = 0; emp = 0; stalled = 0; nchunks = 0;
    if ((a & 32'hFFF) != 0 || (l & 32'hFFF) != 0) rej = 1;
    else if (cur + rem > 64'h1_0000_0000) rej = 1;
    else if (l == 0) emp = 1;
    check("R10", "req_ready idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    if (rej || emp) begin
      check(rej ? "R8" : "R7", "done", {63'd0, done}, 64'd1);
      check(rej ? "R9" : "R7", "err", {63'd0, err}, {63'd0, rej});
      check(rej ? "R8" : "R7", "empty", {63'd0, empty}, {63'd0, emp});
      check(rej ? "R9" : "R7", "no chunk", {63'd0, chk_valid}, 64'd0);
      @(negedge clk);
      check("R10", "done pulse ends", {63'd0, done}, 64'd0);
      return;
    end
    for (int n = 0; n < 80; n++) begin
      bit rdy;
      sz = pick(cur, rem);
      check("R4", "chk_valid", {63'd0, chk_valid}, 64'd1);
      check(stalled ? "R5" : "R1", "base", {32'd0, chk_base}, cur);
      check(stalled ? "R5" : "R2", "size", {32'd0, chk_size}, sz);
      check("R3", "mask", {32'd0, chk_mask}, {32'd0, ~(sz[31:0] - 32'd1)});
      check("R4", "last", {63'd0, chk_last}, {63'd0, rem == sz});
      check("R10", "req_ready busy", {63'd0, req_ready}, 64'd0);
      rdy = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
      chk_ready = rdy;
      @(negedge clk);
      chk_ready = 1'b0;
      stalled = !rdy;
      if (rdy) begin
        nchunks++;
        cur += sz;
        rem -= sz;
        if (rem == 0) begin
          check("R10", "done after last", {61'd0, done, err, empty}, 64'd4);
          check("R4", "idle after last", {63'd0, chk_valid}, 64'd0);
          return;
        end
      end
    end
    check("R4", "range finished", 64'd0, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R10", "reset req_ready", {63'd0, req_ready}, 64'd1);
    check("R4", "reset chk_valid", {63'd0, chk_valid}, 64'd0);
    check("R10", "reset done", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'hA8642000, 32'h0000E000, 0, n);
    check("R2", "chunks at A8642000", n, 3);
    run(32'hE0000000, 32'h0000E000, 1, n);
    check("R2", "chunks at E0000000", n, 3);
    run(32'h00200000, 32'h00200000, 1, n);
    check("R6", "aligned one chunk", n, 1);
    run(32'h40000000, 32'h00001000, 0, n);
    check("R6", "granule one chunk", n, 1);
    run(32'h12345000, 32'h0, 0, n);
    run(32'h12345800, 32'h0, 0, n);
    run(32'h12345004, 32'h1000, 0, n);
    run(32'h12345000, 32'h1100, 0, n);
    run(32'hFFFF0000, 32'h00011000, 0, n);
    run(32'hFFFF0000, 32'h00010000, 1, n);
    check("R9", "top end accepted", n, 1);
    run(32'hFFFFF000, 32'h00001000, 0, n);
    check("R9", "last granule accepted", n, 1);
    run(32'h00000000, 32'hFFFFF000, 1, n);
    check("R2", "full space from zero", n, 20);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, l;
      a = $urandom & 32'hFFFFF000;
      case ($urandom % 4)
        0: l = ($urandom % 64) << 12;
        1: l = $urandom & 32'h00FFF000;
        2: l = $urandom & 32'hFFFFF000;
        default: l = (32'd0 - a) & 32'hFFFFF000;
      endcase
      if ($urandom % 20 == 0) a = a | ($urandom & 32'hFFF);
      run(a, l, 1, n);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule